// File: doc/BRIEF.md
# Correlating Two-Level Branch Predictor

This block guesses whether a conditional branch will be taken. It keeps a short shift register holding the taken/not-taken results of the most recent branches, regardless of which branches they were. That history is joined with a few low-order bits of the branch address to select one saturating counter from a flat table. The top bit of the selected counter is the prediction.

A fetch stage presents a program counter on the lookup port and receives the guess combinationally in the same cycle. When a branch resolves later in the pipeline, the execute stage presents its address and real outcome on the training port. The counter is selected with the history as it stood before that outcome. The counter moves one step toward the outcome, and the outcome is then pushed into the history.

The history length and the counter width are both parameters. A history length of zero turns the block into a plain per-address counter table. Entries carry no tag.

Top module: `corr_branch_predictor`

## Requirements
- R1: After reset the history register holds all zeros and every counter holds 2^(n-1)-1, so every lookup returns not-taken.
- R2: The lookup output is the most significant bit of the counter at index {history, predPc[PC_LSB +: PC_IDX_BITS]}, with history in the upper bits. The output is combinational from predPc in the same cycle.
- R3: A training event with outcome taken increments the selected counter. The counter saturates at 2^n-1 and does not wrap.
- R4: A training event with outcome not-taken decrements the selected counter. The counter saturates at 0 and does not wrap.
- R5: A training event selects its counter with the history value from before its own outcome. The outcome then enters the history at bit 0, the older bits move up one place, and the oldest bit is dropped.
- R6: Every training event shifts the history, whatever its address, so the outcomes of one branch change which counter another branch reads.
- R7: Only the one selected counter changes on a training event. Counters for the same address under other history values keep their values.
- R8: Entries have no tag. Two addresses that differ only above bit PC_LSB+PC_IDX_BITS-1 read and train the same counter.
- R9: When a lookup and a training event fall in the same cycle, the lookup returns the result computed from the state before that training event.
- R10: While updValid is low, updPc and updTaken have no effect: neither the counters nor the history change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| predPc | input | PC_WIDTH | Address of the branch being looked up |
| predTaken | output | 1 | Predicted direction, 1 = taken |
| updValid | input | 1 | A resolved branch is presented this cycle |
| updPc | input | PC_WIDTH | Address of the resolved branch |
| updTaken | input | 1 | Actual outcome of the resolved branch, 1 = taken |

## Verification
Long runs of taken and of not-taken outcomes on one address push a counter against each rail. An extra step past the rail then shows whether it saturates or wraps. Interleaving outcomes from two addresses, then looking up one of them, shows whether the history is shared across branches and how it is shifted. The same sequence also shows whether training used the pre-outcome index and whether neighbouring history contexts were left alone. An address offset just above the index bits exposes the lack of tags. A lookup placed in the same cycle as a training event shows whether the lookup sees the old state. Toggling training data while updValid is low shows whether the block ignores it.

// File: rtl/bp_pkg.sv
package bp_pkg;

  // Strobes sent from the control side to the counter datapath
  typedef struct packed {
    logic trainEn;    // write the selected counter this cycle
    logic trainUp;    // step direction: 1 = toward taken
    logic histShift;  // history advances this cycle
  } bpStrobe_t;

endpackage

// File: rtl/bp_control.sv
module bp_control
  import bp_pkg::*;
#(
  parameter int HIST_BITS = 2,
  parameter int HW        = (HIST_BITS > 0) ? HIST_BITS : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          updValid,
  input  logic          updTaken,
  output bpStrobe_t     strobe,
  output logic [HW-1:0] histVal
);

  always_comb begin
    strobe.trainEn   = updValid;
    strobe.trainUp   = updTaken;
    strobe.histShift = updValid && (HIST_BITS > 0);
  end

  generate
    if (HIST_BITS == 0) begin : g_noHist
      assign histVal = '0;
    end else if (HIST_BITS == 1) begin : g_oneHist
      logic histQ;
      always_ff @(posedge clk) begin
        if (!rstN)                 histQ <= 1'b0;
        else if (strobe.histShift) histQ <= updTaken;
      end
      assign histVal = histQ;
    end else begin : g_multiHist
      logic [HW-1:0] histQ;
      always_ff @(posedge clk) begin
        if (!rstN)                 histQ <= '0;
        else if (strobe.histShift) histQ <= {histQ[HW-2:0], updTaken};
      end
      assign histVal = histQ;
    end
  endgenerate

endmodule

// File: rtl/bp_datapath.sv
module bp_datapath
  import bp_pkg::*;
#(
  parameter int HIST_BITS   = 2,
  parameter int CTR_BITS    = 2,
  parameter int PC_WIDTH    = 32,
  parameter int PC_LSB      = 2,
  parameter int PC_IDX_BITS = 4,
  parameter int HW          = (HIST_BITS > 0) ? HIST_BITS : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  bpStrobe_t           strobe,
  input  logic [HW-1:0]       histVal,
  input  logic [PC_WIDTH-1:0] predPc,
  input  logic [PC_WIDTH-1:0] updPc,
  output logic                predTaken
);

  localparam int IDX_BITS = HIST_BITS + PC_IDX_BITS;
  localparam int DEPTH    = 1 << IDX_BITS;
  localparam logic [CTR_BITS-1:0] CTR_MAX = {CTR_BITS{1'b1}};
  localparam logic [CTR_BITS-1:0] CTR_MIN = '0;
  localparam logic [CTR_BITS-1:0] WEAK_NT = {1'b0, {(CTR_BITS-1){1'b1}}};

  logic [CTR_BITS-1:0] ctrTable [DEPTH];
  logic [IDX_BITS-1:0] rdIdx;
  logic [IDX_BITS-1:0] wrIdx;
  logic [CTR_BITS-1:0] wrOld;
  logic [CTR_BITS-1:0] wrNext;

  generate
    if (HIST_BITS == 0) begin : g_addrOnly
      assign rdIdx = predPc[PC_LSB +: PC_IDX_BITS];
      assign wrIdx = updPc[PC_LSB +: PC_IDX_BITS];
    end else begin : g_correlated
      assign rdIdx = {histVal, predPc[PC_LSB +: PC_IDX_BITS]};
      assign wrIdx = {histVal, updPc[PC_LSB +: PC_IDX_BITS]};
    end
  endgenerate

  assign predTaken = ctrTable[rdIdx][CTR_BITS-1];
  assign wrOld     = ctrTable[wrIdx];

  always_comb begin
    wrNext = wrOld;
    if (strobe.trainUp) begin
      if (wrOld != CTR_MAX) wrNext = wrOld + 1'b1;
    end else begin
      if (wrOld != CTR_MIN) wrNext = wrOld - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) ctrTable[i] <= WEAK_NT;
    end else if (strobe.trainEn) begin
      ctrTable[wrIdx] <= wrNext;
    end
  end

endmodule

// File: rtl/corr_branch_predictor.sv
module corr_branch_predictor
  import bp_pkg::*;
#(
  parameter int HIST_BITS   = 2,
  parameter int CTR_BITS    = 2,
  parameter int PC_WIDTH    = 32,
  parameter int PC_LSB      = 2,
  parameter int PC_IDX_BITS = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [PC_WIDTH-1:0] predPc,
  output logic                predTaken,
  input  logic                updValid,
  input  logic [PC_WIDTH-1:0] updPc,
  input  logic                updTaken
);

  localparam int HW = (HIST_BITS > 0) ? HIST_BITS : 1;

  bpStrobe_t     strobe;
  logic [HW-1:0] histVal;

  bp_control #(
    .HIST_BITS(HIST_BITS),
    .HW       (HW)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .updValid(updValid),
    .updTaken(updTaken),
    .strobe  (strobe),
    .histVal (histVal)
  );

  bp_datapath #(
    .HIST_BITS  (HIST_BITS),
    .CTR_BITS   (CTR_BITS),
    .PC_WIDTH   (PC_WIDTH),
    .PC_LSB     (PC_LSB),
    .PC_IDX_BITS(PC_IDX_BITS),
    .HW         (HW)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .histVal  (histVal),
    .predPc   (predPc),
    .updPc    (updPc),
    .predTaken(predTaken)
  );

endmodule

// File: rtl/bp_checker.sv
module bp_checker #(
  parameter int HIST_BITS = 2,
  parameter int PC_WIDTH  = 32,
  parameter int HW        = (HIST_BITS > 0) ? HIST_BITS : 1
) (
  input logic                clk,
  input logic                rstN,
  input logic                updValid,
  input logic                updTaken,
  input logic [PC_WIDTH-1:0] predPc,
  input logic                predTaken,
  input logic [HW-1:0]       histVal
);

  // R10
  hist_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !updValid |=> $stable(histVal));

  // R10
  pred_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !updValid |=> ($stable(predPc) -> $stable(predTaken)));

  generate
    if (HIST_BITS > 0) begin : g_histLsb
      // R5
      hist_newest_chk: assert property (@(posedge clk) disable iff (!rstN)
        updValid |=> histVal[0] == $past(updTaken));
    end
    if (HIST_BITS >= 2) begin : g_histShift
      // R5
      hist_shift_chk: assert property (@(posedge clk) disable iff (!rstN)
        updValid |=> histVal[HW-1:1] == $past(histVal[HW-2:0]));
    end
  endgenerate

endmodule

bind corr_branch_predictor bp_checker #(
  .HIST_BITS(HIST_BITS),
  .PC_WIDTH (PC_WIDTH)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .updValid (updValid),
  .updTaken (updTaken),
  .predPc   (predPc),
  .predTaken(predTaken),
  .histVal  (histVal)
);

// File: tb/corr_branch_predictor_bench.sv
module corr_branch_predictor_bench;

  localparam int PC_WIDTH = 32;
  localparam logic [PC_WIDTH-1:0] PC_A  = 32'h0000_0010; // index bits = 4
  localparam logic [PC_WIDTH-1:0] PC_B  = 32'h0000_0020; // index bits = 8
  localparam logic [PC_WIDTH-1:0] PC_C  = 32'h0000_0004; // index bits = 1
  localparam logic [PC_WIDTH-1:0] PC_A2 = 32'h0000_0050; // aliases PC_A

  logic                clk = 1'b0;
  logic                rstN = 1'b0;
  logic [PC_WIDTH-1:0] predPc = '0;
  logic                predTaken;
  logic                updValid = 1'b0;
  logic [PC_WIDTH-1:0] updPc = '0;
  logic                updTaken = 1'b0;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk; // 50 MHz

  corr_branch_predictor #(
    .HIST_BITS(2), .CTR_BITS(2), .PC_WIDTH(PC_WIDTH), .PC_LSB(2), .PC_IDX_BITS(4)
  ) u_corr_branch_predictor (
    .clk(clk), .rstN(rstN), .predPc(predPc), .predTaken(predTaken),
    .updValid(updValid), .updPc(updPc), .updTaken(updTaken)
  );

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; updValid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic train(input logic [PC_WIDTH-1:0] pc, input logic tk);
    @(negedge clk);
    updValid = 1'b1; updPc = pc; updTaken = tk;
    @(negedge clk);
    updValid = 1'b0;
  endtask

  task automatic expectPred(input logic [PC_WIDTH-1:0] pc, input logic exp, input string tag);
    predPc = pc;
    #2;
    checks++;
    if (predTaken !== exp) begin
      fails++;
      $display("FAIL %s pc=%h actual=%b expected=%b", tag, pc, predTaken, exp);
    end
  endtask

  // R1: reset state predicts not-taken everywhere
  task automatic testReset();
    doReset();
    @(negedge clk);
    expectPred(PC_A, 1'b0, "R1 reset A");
    expectPred(PC_B, 1'b0, "R1 reset B");
    expectPred(PC_C, 1'b0, "R1 reset C");
  endtask

  // R3 and R2: taken saturation at the top of the counter range
  task automatic testSatUp();
    doReset();
    train(PC_A, 1'b1);            // ctr{00,A}=2, hist 01
    expectPred(PC_A, 1'b0, "R2 hist01 untouched context");
    train(PC_A, 1'b1);            // ctr{01,A}=2, hist 11
    train(PC_A, 1'b1);            // ctr{11,A}=2
    expectPred(PC_A, 1'b1, "R2 msb of weakly taken");
    train(PC_A, 1'b1);            // ctr{11,A}=3
    train(PC_A, 1'b1);            // stays 3
    expectPred(PC_A, 1'b1, "R3 saturate high");
  endtask

  // R4: not-taken saturation at zero
  task automatic testSatDown();
    doReset();
    train(PC_A, 1'b0);            // ctr{00,A}=0
    train(PC_A, 1'b0);            // stays 0
    train(PC_A, 1'b0);            // stays 0
    expectPred(PC_A, 1'b0, "R4 low");
    train(PC_A, 1'b1);            // ctr{00,A}=1, hist 01
    train(PC_B, 1'b0);            // hist 10
    train(PC_B, 1'b0);            // hist 00
    expectPred(PC_A, 1'b0, "R4 saturate low");
  endtask

  // R5, R6, R7: shared history, pre-shift index, single-entry training
  task automatic testCorrelation();
    doReset();
    train(PC_B, 1'b1);            // ctr{00,B}=2, hist 01
    train(PC_A, 1'b1);            // ctr{01,A}=2, hist 11
    expectPred(PC_A, 1'b0, "R7 hist11 context untouched");
    expectPred(PC_B, 1'b0, "R5 index used pre-shift history");
    train(PC_B, 1'b0);            // ctr{11,B}=0, hist 10
    train(PC_B, 1'b1);            // ctr{10,B}=2, hist 01
    expectPred(PC_A, 1'b1, "R6 other branch outcomes select A entry");
    expectPred(PC_C, 1'b0, "R7 other address untouched");
    expectPred(PC_A2, 1'b1, "R8 alias shares counter");
  endtask

  // R9: lookup in the same cycle as training sees old state
  task automatic testSameCycle();
    doReset();
    @(negedge clk);
    updValid = 1'b1; updPc = PC_A; updTaken = 1'b1;
    expectPred(PC_A, 1'b0, "R9 same-cycle old state");
    @(negedge clk);
    updValid = 1'b0;
    train(PC_B, 1'b0);            // hist 10
    train(PC_B, 1'b0);            // hist 00
    expectPred(PC_A, 1'b1, "R9 training took effect afterwards");
  endtask

  // R10: training data ignored without updValid
  task automatic testIgnored();
    doReset();
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      updValid = 1'b0; updPc = PC_A; updTaken = 1'b1;
    end
    @(negedge clk);
    expectPred(PC_A, 1'b0, "R10 counters unchanged");
    train(PC_A, 1'b1);            // if history stayed 00: ctr{00,A}=2, hist 01
    train(PC_B, 1'b0);            // hist 10
    train(PC_B, 1'b0);            // hist 00
    expectPred(PC_A, 1'b1, "R10 history unchanged");
  endtask

  initial begin
    testReset();
    testSatUp();
    testSatDown();
    testCorrelation();
    testSameCycle();
    testIgnored();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 20);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule